// File: doc/BRIEF.md
# Configuration Cycle Claim Decoder

This block sits in the target side of a graphics bus master. It watches each address phase on the shared address/data bus. It decides whether the access is a configuration cycle aimed at this device. When it is, the block claims the cycle by driving an active-low device-select. It also hands the configuration-space logic a function number, a register index and a read/write flag.

A static strap chooses one of two ways to find the select condition. In dedicated-port mode the device has no external select pin, so address bit 16 acts as the select. In shared-bus mode a separate select input is used. The board decides which address line drives that input. The strap is sampled only while reset is held.

The control is a two-state machine. `ST_IDLE` means no claim is in progress. `ST_CLAIMED` means the cycle is claimed and device-select is driven low. The transition `ST_IDLE -> ST_CLAIMED` is taken on a decoded hit. The transition `ST_CLAIMED -> ST_IDLE` is taken when the data phase completes. Reset forces `ST_IDLE`.

Top module: `cfg_claim_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `dev_sel_n` is 1 and `func_num`, `reg_idx` and `cfg_wr` are 0.
- R2: Only the command codes 4'b1010 (configuration read) and 4'b1011 (configuration write) can be claimed. Every other command is left unclaimed.
- R3: An access is claimed only when address bits 1:0 are 2'b00.
- R4: With the strap latched high (dedicated-port mode), the select condition is `addr[16]` = 1, and `ext_sel` has no effect.
- R5: With the strap latched low (shared-bus mode), the select condition is `ext_sel` = 1, and `addr[16]` has no effect.
- R6: The strap is sampled on every clock while `rst_n` is low. The last sampled value is kept until the next reset, and later changes of `strap_dedicated` have no effect.
- R7: When `hdr_multi` is 0 (single-function device), an access is claimed only if `addr[10:8]` is 0.
- R8: When `hdr_multi` is 1 (multi-function device), any value of `addr[10:8]` can be claimed, and it is reported on `func_num`.
- R9: `dev_sel_n` goes low on the clock after an address phase that hits. It stays low until the clock after a cycle in which `data_done` is 1, and then it returns high.
- R10: On a claim, `reg_idx` takes `addr[7:2]` and `cfg_wr` takes `cmd[0]` (1 = write). These values are held until the next claim.
- R11: While a claim is in progress, new address phases are ignored: `func_num`, `reg_idx` and `cfg_wr` do not change, and the claim still ends only on `data_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_dedicated | input | 1 | Mode strap: 1 selects dedicated-port mode, 0 selects shared-bus mode |
| ext_sel | input | 1 | External select, used in shared-bus mode |
| hdr_multi | input | 1 | Multi-function flag, taken from the header-type field |
| addr_valid | input | 1 | High during an address phase |
| cmd | input | 4 | Bus command sampled in the address phase |
| addr | input | 32 | Address sampled in the address phase |
| data_done | input | 1 | Data phase of the claimed cycle completes this cycle |
| dev_sel_n | output | 1 | Active-low device-select (claim) |
| func_num | output | 3 | Function number of the claimed access |
| reg_idx | output | 6 | Register (dword) index of the claimed access |
| cfg_wr | output | 1 | Claimed access is a configuration write |

## Verification
The claim condition is tried one condition at a time. Each case keeps three conditions true and breaks one: the command, the low address bits, the select, or the function number. A missing term in the decode therefore shows up as a false claim. Select is driven in four ways: internal select only, external select only, in each strap mode, and with the strap toggled after reset. This tells the two select sources apart and separates a latched strap from a live one. Claims are also held over several idle data cycles and hit by stray address phases. These cases expose early release and field overwrite, and a per-clock reference model compares every output on every cycle.

// File: rtl/cfg_claim_pkg.sv
package cfg_claim_pkg;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_CFG_READ  = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_CFG_WRITE = 4'b1011;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_CLAIMED = 1'b1
    } claim_state_t;

endpackage

// File: rtl/cfg_strap_latch.sv
module cfg_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_in,
    output logic mode_dedicated
);

    // Follows the strap pin for as long as reset is held, then freezes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_dedicated <= strap_in;
        end
    end

    // R6: the latched mode never moves outside reset
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_dedicated));

endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_claim_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEL_BIT  = 16,
    parameter int FUNC_LSB = 8,
    parameter int FUNC_W   = 3,
    parameter int REG_LSB  = 2,
    parameter int REG_W    = 6
) (
    input  logic              mode_dedicated,
    input  logic              ext_sel,
    input  logic              hdr_multi,
    input  logic              addr_valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [FUNC_W-1:0] func_dec,
    output logic [REG_W-1:0]  reg_dec,
    output logic              wr_dec
);

    localparam int ALIGN_W = REG_LSB;

    logic is_cfg_cmd;
    logic aligned;
    logic selected;
    logic func_ok;
    logic unused_addr;

    assign unused_addr = ^addr;

    always_comb begin
        is_cfg_cmd = (cmd == CMD_CFG_READ) || (cmd == CMD_CFG_WRITE);
        aligned    = (addr[ALIGN_W-1:0] == '0);
        selected   = mode_dedicated ? addr[SEL_BIT] : ext_sel;
        func_dec   = addr[FUNC_LSB +: FUNC_W];
        func_ok    = hdr_multi || (func_dec == '0);
        reg_dec    = addr[REG_LSB +: REG_W];
        wr_dec     = cmd[0];
        hit        = addr_valid && is_cfg_cmd && aligned && selected && func_ok;
    end

endmodule

// File: rtl/cfg_claim_fsm.sv
module cfg_claim_fsm
    import cfg_claim_pkg::*;
#(
    parameter int FUNC_W = 3,
    parameter int REG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [FUNC_W-1:0] func_dec,
    input  logic [REG_W-1:0]  reg_dec,
    input  logic              wr_dec,
    input  logic              data_done,
    output logic              dev_sel_n,
    output logic [FUNC_W-1:0] func_num,
    output logic [REG_W-1:0]  reg_idx,
    output logic              cfg_wr
);

    claim_state_t state_q;
    claim_state_t state_d;
    logic         take_claim;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d    = state_q;
        take_claim = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hit) begin
                    state_d    = ST_CLAIMED;
                    take_claim = 1'b1;
                end
            end
            ST_CLAIMED: begin
                if (data_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_num <= '0;
            reg_idx  <= '0;
            cfg_wr   <= 1'b0;
        end else if (take_claim) begin
            func_num <= func_dec;
            reg_idx  <= reg_dec;
            cfg_wr   <= wr_dec;
        end
    end

    assign dev_sel_n = (state_q != ST_CLAIMED);

    // R9: a hit while idle turns into a claim on the next clock
    a_r9_claim_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hit) |=> !dev_sel_n);

    // R9: a claim is held until the data phase completes
    a_r9_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_sel_n && !data_done) |=> !dev_sel_n);

    // R9: completion releases the select
    a_r9_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_sel_n && data_done) |=> dev_sel_n);

    // R11: claim fields do not move while a claim is in progress
    a_r11_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_sel_n && !data_done) |=>
            ($stable(func_num) && $stable(reg_idx) && $stable(cfg_wr)));

endmodule

// File: rtl/cfg_claim_decoder.sv
module cfg_claim_decoder
    import cfg_claim_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEL_BIT  = 16,
    parameter int FUNC_LSB = 8,
    parameter int FUNC_W   = 3,
    parameter int REG_LSB  = 2,
    parameter int REG_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_dedicated,
    input  logic              ext_sel,
    input  logic              hdr_multi,
    input  logic              addr_valid,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              data_done,
    output logic              dev_sel_n,
    output logic [FUNC_W-1:0] func_num,
    output logic [REG_W-1:0]  reg_idx,
    output logic              cfg_wr
);

    logic              mode_dedicated;
    logic              hit;
    logic [FUNC_W-1:0] func_dec;
    logic [REG_W-1:0]  reg_dec;
    logic              wr_dec;

    cfg_strap_latch u_strap (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_in       (strap_dedicated),
        .mode_dedicated (mode_dedicated)
    );

    cfg_addr_decode #(
        .ADDR_W   (ADDR_W),
        .SEL_BIT  (SEL_BIT),
        .FUNC_LSB (FUNC_LSB),
        .FUNC_W   (FUNC_W),
        .REG_LSB  (REG_LSB),
        .REG_W    (REG_W)
    ) u_decode (
        .mode_dedicated (mode_dedicated),
        .ext_sel        (ext_sel),
        .hdr_multi      (hdr_multi),
        .addr_valid     (addr_valid),
        .cmd            (cmd),
        .addr           (addr),
        .hit            (hit),
        .func_dec       (func_dec),
        .reg_dec        (reg_dec),
        .wr_dec         (wr_dec)
    );

    cfg_claim_fsm #(
        .FUNC_W (FUNC_W),
        .REG_W  (REG_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .func_dec  (func_dec),
        .reg_dec   (reg_dec),
        .wr_dec    (wr_dec),
        .data_done (data_done),
        .dev_sel_n (dev_sel_n),
        .func_num  (func_num),
        .reg_idx   (reg_idx),
        .cfg_wr    (cfg_wr)
    );

    // R7: a single-function device only ever reports function zero while claimed
    a_r7_single_func_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_sel_n && !hdr_multi && $past(dev_sel_n)) |-> (func_num == '0));

    // R2: no claim starts from a non-configuration command
    a_r2_cfg_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel_n && addr_valid && (cmd[3:1] != 3'b101)) |=> dev_sel_n);

    // R3: no claim starts from an unaligned address
    a_r3_aligned_only: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel_n && addr_valid && (addr[1:0] != 2'b00)) |=> dev_sel_n);

endmodule

// File: tb/cfg_claim_decoder_test.sv
module cfg_claim_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_dedicated = 1'b1;
    logic        ext_sel = 1'b0;
    logic        hdr_multi = 1'b0;
    logic        addr_valid = 1'b0;
    logic [3:0]  cmd = 4'h0;
    logic [31:0] addr = 32'h0;
    logic        data_done = 1'b0;
    logic        dev_sel_n;
    logic [2:0]  func_num;
    logic [5:0]  reg_idx;
    logic        cfg_wr;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model state
    bit       m_mode;
    bit       m_claim;
    bit [2:0] m_func;
    bit [5:0] m_reg;
    bit       m_wr;

    always #4 clk = ~clk;

    cfg_claim_decoder uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_dedicated (strap_dedicated),
        .ext_sel         (ext_sel),
        .hdr_multi       (hdr_multi),
        .addr_valid      (addr_valid),
        .cmd             (cmd),
        .addr            (addr),
        .data_done       (data_done),
        .dev_sel_n       (dev_sel_n),
        .func_num        (func_num),
        .reg_idx         (reg_idx),
        .cfg_wr          (cfg_wr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit model_hit();
        bit sel;
        bit cfg;
        sel = m_mode ? addr[16] : ext_sel;
        cfg = (cmd == 4'b1010) || (cmd == 4'b1011);
        return addr_valid && cfg && (addr[1:0] == 2'b00) && sel &&
               (hdr_multi || addr[10:8] == 3'd0);
    endfunction

    // one clock: advance the model on the edge, compare at the falling edge
    task automatic step(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_mode  = strap_dedicated;
            m_claim = 1'b0;
            m_func  = '0;
            m_reg   = '0;
            m_wr    = 1'b0;
        end else if (m_claim) begin
            if (data_done) m_claim = 1'b0;
        end else if (model_hit()) begin
            m_claim = 1'b1;
            m_func  = addr[10:8];
            m_reg   = addr[7:2];
            m_wr    = cmd[0];
        end
        @(negedge clk);
        check(tag, "dev_sel_n", int'(dev_sel_n), int'(!m_claim));
        check(tag, "func_num", int'(func_num), int'(m_func));
        check(tag, "reg_idx", int'(reg_idx), int'(m_reg));
        check(tag, "cfg_wr", int'(cfg_wr), int'(m_wr));
    endtask

    task automatic addr_phase(input string tag, input logic [3:0] c, input logic [31:0] a);
        addr_valid = 1'b1;
        cmd        = c;
        addr       = a;
        step(tag);
        addr_valid = 1'b0;
        cmd        = 4'h0;
        addr       = 32'h0;
    endtask

    task automatic finish_data(input string tag);
        data_done = 1'b1;
        step(tag);
        data_done = 1'b0;
        step(tag);
    endtask

    task automatic do_reset(input string tag, input bit strap);
        rst_n = 1'b0;
        strap_dedicated = strap;
        step(tag);
        step(tag);
        rst_n = 1'b1;
        step(tag);
    endtask

    initial begin
        @(negedge clk);
        // R1 / R6: reset with dedicated-port strap
        do_reset("R1", 1'b1);
        check("R1", "dev_sel_n after reset", int'(dev_sel_n), 1);

        // R6: strap changes after reset have no effect
        strap_dedicated = 1'b0;

        // R9 / R10: read claim, function 0, register 5, held over idle data cycles
        addr_phase("R9", 4'b1010, 32'h0001_0014);
        check("R10", "reg_idx on claim", int'(reg_idx), 5);
        step("R9");
        // R11: stray address phase during claim
        addr_phase("R11", 4'b1011, 32'h0001_00FC);
        step("R9");
        finish_data("R9");

        // R4: external select alone does not claim in dedicated mode
        ext_sel = 1'b1;
        addr_phase("R4", 4'b1010, 32'h0000_0008);
        step("R4");
        ext_sel = 1'b0;
        // R6: same access again with the pin now low: still dedicated behaviour
        addr_phase("R6", 4'b1011, 32'h0001_0008);
        check("R6", "claim in latched dedicated mode", int'(dev_sel_n), 0);
        finish_data("R6");

        // R2: memory read command with select high is not claimed
        addr_phase("R2", 4'b0110, 32'h0001_0000);
        step("R2");
        // R3: unaligned address
        addr_phase("R3", 4'b1010, 32'h0001_0001);
        addr_phase("R3", 4'b1011, 32'h0001_0002);
        step("R3");
        // R7: single function, function 3 not claimed
        addr_phase("R7", 4'b1010, 32'h0001_0300);
        step("R7");

        // R5: shared-bus mode
        do_reset("R5", 1'b0);
        strap_dedicated = 1'b1;
        addr_phase("R5", 4'b1010, 32'h0001_0010);
        step("R5");
        ext_sel = 1'b1;
        addr_phase("R5", 4'b1011, 32'h0000_0020);
        check("R5", "claim via external select", int'(dev_sel_n), 0);
        check("R10", "write flag", int'(cfg_wr), 1);
        finish_data("R5");

        // R8: multi-function device, function 5
        hdr_multi = 1'b1;
        addr_phase("R8", 4'b1010, 32'h0000_0530);
        check("R8", "func_num", int'(func_num), 5);
        step("R8");
        finish_data("R8");
        // R8 / R11: back-to-back address phase on the release cycle and then a new claim
        addr_phase("R8", 4'b1011, 32'h0000_07FC);
        data_done = 1'b1;
        addr_phase("R11", 4'b1010, 32'h0000_0104);
        data_done = 1'b0;
        step("R11");
        hdr_multi = 1'b0;
        ext_sel = 1'b0;

        // R1: reset in the middle of a claim
        ext_sel = 1'b1;
        addr_phase("R1", 4'b1010, 32'h0000_0004);
        do_reset("R1", 1'b1);
        check("R1", "dev_sel_n after mid-claim reset", int'(dev_sel_n), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule